// File: doc/BRIEF.md
# Page Translation Buffer with Age-Ordered Replacement

The block holds a small set of recently used page mappings and turns a virtual address into a physical address in the same cycle it is presented. Pages are 4 KB, so the low 12 address bits go straight through and only the upper bits are translated. Every stored mapping is compared against the incoming page number in parallel. There are no index bits, so any mapping can occupy any slot.

When no slot matches, the block raises a miss flag. An external handler then fetches the page-table entry and writes it in through the refill port, and the access is retried. Each slot keeps a valid bit, a reference bit and a dirty bit. A hit sets the reference bit, and a write hit also sets the dirty bit. A one-cycle clear input wipes every reference bit at once. A refill goes to the lowest-numbered empty slot. When every slot is full, it replaces the slot that has gone unused the longest, and it overwrites a slot that already holds the same page number rather than creating a second copy.

Top module: `pgxlat_tlb`

## Requirements
- R1: After reset every slot is empty, so any lookup reports a miss.
- R2: On a hit, lk_paddr is the stored physical page number in bits 31:12, with the request's bits 11:0 passed through unchanged, in the same cycle as the request.
- R3: lk_miss is 1 exactly when lk_valid is 1 and no valid slot matches. lk_hit and lk_miss are never both 1, and both are 0 when lk_valid is 0.
- R4: A refill presented in one cycle makes a lookup of that page number hit from the next cycle onward, with the refilled physical page number.
- R5: A hit reports the slot's stored reference bit on lk_ref and sets that bit at the clock edge, so a following hit on the same page reports lk_ref = 1. A freshly refilled slot has its reference bit at 0.
- R6: A write hit (lk_write = 1) sets the slot's dirty bit, and a read hit leaves it unchanged. A refill loads the dirty bit from rf_dirty. The stored bit is reported on lk_dirty.
- R7: A cycle with clr_ref = 1 clears the reference bit of every slot. If a hit happens in that same cycle, the hit slot's reference bit ends up 1.
- R8: While empty slots remain, a refill fills an empty slot and evicts nothing, so all 16 distinct refilled pages stay resident.
- R9: When all slots are valid, a refill of a new page replaces the least recently used slot. Both hits and refills count as use.
- R10: A refill whose page number is already resident overwrites that slot's mapping and evicts no other slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request present |
| lk_write | input | 1 | Lookup is a store (1) or a load (0) |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_hit | output | 1 | Translation found |
| lk_miss | output | 1 | No translation; handler must refill and retry |
| lk_paddr | output | 32 | Translated physical address |
| lk_ref | output | 1 | Stored reference bit of the hit slot |
| lk_dirty | output | 1 | Stored dirty bit of the hit slot |
| rf_valid | input | 1 | Install a mapping this cycle |
| rf_vpn | input | 20 | Virtual page number to install |
| rf_ppn | input | 20 | Physical page number to install |
| rf_dirty | input | 1 | Initial dirty bit of the installed mapping |
| clr_ref | input | 1 | Clear all reference bits |

## Verification
The bench fills all slots and then touches one page before refilling. A design that evicted by slot number or by fill order instead of by last use would remove the wrong page. It also refills a page that is already resident. A design without that check would create a duplicate and push out an unrelated page. The reference and dirty bits are read back through the hit outputs around a read-only access, a clear that coincides with a hit, and a write. This catches a bit set by reads, a bit left uncleared, and a clear that wins over the access in the same cycle.

// File: rtl/pgxlat_pkg.sv
package pgxlat_pkg;
    localparam int VA_W  = 32;
    localparam int PA_W  = 32;
    localparam int OFF_W = 12;
    localparam int VPN_W = VA_W - OFF_W;
    localparam int PPN_W = PA_W - OFF_W;

    typedef struct packed {
        logic             vld;
        logic             ref_b;
        logic             dirty;
        logic [VPN_W-1:0] vpn;
        logic [PPN_W-1:0] ppn;
    } tlb_ent_t;

    function automatic logic [VPN_W-1:0] page_num(input logic [VA_W-1:0] a);
        return a[VA_W-1:OFF_W];
    endfunction

    function automatic logic [OFF_W-1:0] page_off(input logic [VA_W-1:0] a);
        return a[OFF_W-1:0];
    endfunction
endpackage

// File: rtl/pgxlat_cam.sv
module pgxlat_cam
    import pgxlat_pkg::*;
#(
    parameter int N_ENT = 16,
    localparam int IDX_W = $clog2(N_ENT)
) (
    input  tlb_ent_t         ent [N_ENT],
    input  logic [VPN_W-1:0] key,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    logic [N_ENT-1:0] match;

    for (genvar g = 0; g < N_ENT; g++) begin : g_cmp
        assign match[g] = ent[g].vld && (ent[g].vpn == key);
    end

    always_comb begin
        idx = '0;
        for (int i = N_ENT - 1; i >= 0; i--) begin
            if (match[i]) idx = IDX_W'(i);
        end
    end

    assign any = |match;
endmodule

// File: rtl/pgxlat_lru.sv
module pgxlat_lru #(
    parameter int N_ENT = 16,
    localparam int IDX_W = $clog2(N_ENT)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             upd,
    input  logic [IDX_W-1:0] upd_idx,
    input  logic [N_ENT-1:0] vld,
    output logic [IDX_W-1:0] victim
);
    logic [IDX_W-1:0] age [N_ENT];
    logic [IDX_W-1:0] used_age;

    assign used_age = age[upd_idx];

    for (genvar g = 0; g < N_ENT; g++) begin : g_age
        always_ff @(posedge clk) begin
            if (rst) begin
                age[g] <= IDX_W'(g);
            end else if (upd) begin
                if (upd_idx == IDX_W'(g))  age[g] <= '0;
                else if (age[g] < used_age) age[g] <= age[g] + 1'b1;
            end
        end
    end

    always_comb begin
        logic found_free;
        logic [IDX_W-1:0] oldest;
        found_free = 1'b0;
        victim     = '0;
        oldest     = '0;
        for (int i = N_ENT - 1; i >= 0; i--) begin
            if (!vld[i]) begin
                victim     = IDX_W'(i);
                found_free = 1'b1;
            end
        end
        if (!found_free) begin
            for (int i = 0; i < N_ENT; i++) begin
                if (age[i] >= oldest) begin
                    oldest = age[i];
                    victim = IDX_W'(i);
                end
            end
        end
    end
endmodule

// File: rtl/pgxlat_tlb.sv
module pgxlat_tlb
    import pgxlat_pkg::*;
#(
    parameter int N_ENT = 16,
    localparam int IDX_W = $clog2(N_ENT)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             lk_valid,
    input  logic             lk_write,
    input  logic [VA_W-1:0]  lk_vaddr,
    output logic             lk_hit,
    output logic             lk_miss,
    output logic [PA_W-1:0]  lk_paddr,
    output logic             lk_ref,
    output logic             lk_dirty,
    input  logic             rf_valid,
    input  logic [VPN_W-1:0] rf_vpn,
    input  logic [PPN_W-1:0] rf_ppn,
    input  logic             rf_dirty,
    input  logic             clr_ref
);
    tlb_ent_t         ent [N_ENT];
    logic [N_ENT-1:0] vld_vec;
    logic             lk_any, rf_any, lk_touch;
    logic [IDX_W-1:0] lk_idx, rf_idx, victim, rf_tgt, lru_idx;

    pgxlat_cam #(.N_ENT(N_ENT)) u_lk_cam (
        .ent(ent), .key(page_num(lk_vaddr)), .any(lk_any), .idx(lk_idx));

    pgxlat_cam #(.N_ENT(N_ENT)) u_rf_cam (
        .ent(ent), .key(rf_vpn), .any(rf_any), .idx(rf_idx));

    for (genvar g = 0; g < N_ENT; g++) begin : g_vld
        assign vld_vec[g] = ent[g].vld;
    end

    assign rf_tgt   = rf_any ? rf_idx : victim;
    assign lk_touch = lk_valid && lk_any && !rf_valid;
    assign lru_idx  = rf_valid ? rf_tgt : lk_idx;

    pgxlat_lru #(.N_ENT(N_ENT)) u_lru (
        .clk(clk), .rst(rst), .upd(rf_valid || lk_touch),
        .upd_idx(lru_idx), .vld(vld_vec), .victim(victim));

    for (genvar g = 0; g < N_ENT; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst) begin
                ent[g] <= '0;
            end else begin
                if (clr_ref) ent[g].ref_b <= 1'b0;
                if (lk_touch && lk_idx == IDX_W'(g)) begin
                    ent[g].ref_b <= 1'b1;
                    if (lk_write) ent[g].dirty <= 1'b1;
                end
                if (rf_valid && rf_tgt == IDX_W'(g)) begin
                    ent[g] <= '{vld: 1'b1, ref_b: 1'b0, dirty: rf_dirty,
                                vpn: rf_vpn, ppn: rf_ppn};
                end
            end
        end
    end

    assign lk_hit   = lk_valid && lk_any;
    assign lk_miss  = lk_valid && !lk_any;
    assign lk_paddr = {ent[lk_idx].ppn, page_off(lk_vaddr)};
    assign lk_ref   = lk_hit && ent[lk_idx].ref_b;
    assign lk_dirty = lk_hit && ent[lk_idx].dirty;
endmodule

// File: rtl/pgxlat_tlb_chk.sv
module pgxlat_tlb_chk
    import pgxlat_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             lk_valid,
    input logic             lk_write,
    input logic [VA_W-1:0]  lk_vaddr,
    input logic             lk_hit,
    input logic             lk_miss,
    input logic [PA_W-1:0]  lk_paddr,
    input logic             lk_ref,
    input logic             lk_dirty,
    input logic             rf_valid,
    input logic [VPN_W-1:0] rf_vpn,
    input logic [PPN_W-1:0] rf_ppn,
    input logic             clr_ref
);
    assert_empty_after_reset_R1: assert property (@(posedge clk)
        rst |=> !lk_hit);

    assert_offset_passes_R2: assert property (@(posedge clk) disable iff (rst)
        lk_hit |-> lk_paddr[OFF_W-1:0] == lk_vaddr[OFF_W-1:0]);

    assert_hit_miss_excl_R3: assert property (@(posedge clk) disable iff (rst)
        !(lk_hit && lk_miss) && (lk_valid || (!lk_hit && !lk_miss)));

    assert_refill_visible_R4: assert property (@(posedge clk) disable iff (rst)
        rf_valid |=> (!(lk_valid && lk_vaddr[VA_W-1:OFF_W] == $past(rf_vpn))
                      || (lk_hit && lk_paddr[PA_W-1:OFF_W] == $past(rf_ppn))));

    assert_ref_on_use_R5: assert property (@(posedge clk) disable iff (rst)
        (lk_hit && !rf_valid) |=>
            (!(lk_valid && lk_vaddr == $past(lk_vaddr)) || lk_ref));

    assert_dirty_on_write_R6: assert property (@(posedge clk) disable iff (rst)
        (lk_hit && lk_write && !rf_valid) |=>
            (!(lk_valid && lk_vaddr == $past(lk_vaddr)) || lk_dirty));

    assert_clear_ref_R7: assert property (@(posedge clk) disable iff (rst)
        (clr_ref && !lk_valid && !rf_valid) |=> !lk_ref);
endmodule

bind pgxlat_tlb pgxlat_tlb_chk u_chk (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_write(lk_write),
    .lk_vaddr(lk_vaddr), .lk_hit(lk_hit), .lk_miss(lk_miss),
    .lk_paddr(lk_paddr), .lk_ref(lk_ref), .lk_dirty(lk_dirty),
    .rf_valid(rf_valid), .rf_vpn(rf_vpn), .rf_ppn(rf_ppn), .clr_ref(clr_ref));

// File: tb/tb_pgxlat_tlb.sv
`timescale 1ns/1ps
module tb_pgxlat_tlb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        lk_valid = 1'b0, lk_write = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic        lk_hit, lk_miss, lk_ref, lk_dirty;
    logic [31:0] lk_paddr;
    logic        rf_valid = 1'b0, rf_dirty = 1'b0, clr_ref = 1'b0;
    logic [19:0] rf_vpn = '0, rf_ppn = '0;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    logic        s_hit, s_miss, s_ref, s_dirty;
    logic [31:0] s_pa;

    always #2.5 clk = ~clk;

    pgxlat_tlb dut (
        .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_write(lk_write),
        .lk_vaddr(lk_vaddr), .lk_hit(lk_hit), .lk_miss(lk_miss),
        .lk_paddr(lk_paddr), .lk_ref(lk_ref), .lk_dirty(lk_dirty),
        .rf_valid(rf_valid), .rf_vpn(rf_vpn), .rf_ppn(rf_ppn),
        .rf_dirty(rf_dirty), .clr_ref(clr_ref));

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk); rst = 1'b0;
    endtask

    task automatic refill(input logic [19:0] vpn, input logic [19:0] ppn,
                          input logic d);
        @(negedge clk);
        rf_valid = 1'b1; rf_vpn = vpn; rf_ppn = ppn; rf_dirty = d;
        @(posedge clk); #1;
        rf_valid = 1'b0;
    endtask

    task automatic look(input logic [31:0] va, input logic wr, input logic clr);
        @(negedge clk);
        lk_valid = 1'b1; lk_vaddr = va; lk_write = wr; clr_ref = clr;
        #1;
        s_hit = lk_hit; s_miss = lk_miss; s_pa = lk_paddr;
        s_ref = lk_ref; s_dirty = lk_dirty;
        @(posedge clk); #1;
        lk_valid = 1'b0; lk_write = 1'b0; clr_ref = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        look(32'h0000_0000, 0, 0);
        chk(s_miss && !s_hit, "R1 miss after reset", {30'd0, s_hit, s_miss}, 32'h1);
        look(32'hFFFF_F123, 0, 0);
        chk(s_miss && !s_hit, "R1 miss after reset hi", {30'd0, s_hit, s_miss}, 32'h1);
    endtask

    task automatic t_basic();
        refill(20'h12345, 20'hABCDE, 0);
        look(32'h1234_5678, 0, 0);
        chk(s_hit && !s_miss, "R4 hit after refill", {31'd0, s_hit}, 32'h1);
        chk(s_pa == 32'hABCD_E678, "R2 translated address", s_pa, 32'hABCD_E678);
        look(32'h1234_5FFF, 0, 0);
        chk(s_pa == 32'hABCD_EFFF, "R2 offset top", s_pa, 32'hABCD_EFFF);
        look(32'h1234_6000, 0, 0);
        chk(s_miss && !s_hit, "R3 neighbour page misses", {30'd0, s_hit, s_miss}, 32'h1);
        @(negedge clk); lk_valid = 1'b0; lk_vaddr = 32'h1234_5000; #1;
        chk(!lk_hit && !lk_miss, "R3 idle no flags", {30'd0, lk_hit, lk_miss}, 32'h0);
    endtask

    task automatic t_ref();
        refill(20'h00040, 20'h00777, 0);
        look(32'h0004_0010, 0, 0);
        chk(s_hit && !s_ref, "R5 fresh ref clear", {31'd0, s_ref}, 32'h0);
        look(32'h0004_0010, 0, 0);
        chk(s_ref, "R5 ref set by use", {31'd0, s_ref}, 32'h1);
        @(negedge clk); clr_ref = 1'b1; @(posedge clk); #1; clr_ref = 1'b0;
        look(32'h0004_0010, 0, 0);
        chk(!s_ref, "R7 ref cleared", {31'd0, s_ref}, 32'h0);
        look(32'h0004_0020, 0, 1);
        look(32'h0004_0030, 0, 0);
        chk(s_ref, "R7 access beats clear", {31'd0, s_ref}, 32'h1);
    endtask

    task automatic t_dirty();
        refill(20'h00050, 20'h000AB, 0);
        look(32'h0005_0000, 0, 0);
        chk(s_hit && !s_dirty, "R6 fresh clean", {31'd0, s_dirty}, 32'h0);
        look(32'h0005_0000, 0, 0);
        chk(!s_dirty, "R6 read keeps clean", {31'd0, s_dirty}, 32'h0);
        look(32'h0005_0004, 1, 0);
        look(32'h0005_0008, 0, 0);
        chk(s_dirty, "R6 write sets dirty", {31'd0, s_dirty}, 32'h1);
        refill(20'h00051, 20'h000AC, 1);
        look(32'h0005_1000, 0, 0);
        chk(s_hit && s_dirty, "R6 refill loads dirty", {31'd0, s_dirty}, 32'h1);
    endtask

    task automatic t_lru();
        do_reset();
        for (int i = 0; i < 16; i++) refill(20'h00100 + 20'(i), 20'h00500 + 20'(i), 0);
        for (int i = 0; i < 16; i++) begin
            look({20'h00100 + 20'(i), 12'h004}, 0, 0);
            chk(s_hit && s_pa == {20'h00500 + 20'(i), 12'h004}, "R8 all resident",
                s_pa, {20'h00500 + 20'(i), 12'h004});
        end
        look(32'h0010_0000, 0, 0);
        refill(20'h00200, 20'h00600, 0);
        look(32'h0010_1000, 0, 0);
        chk(s_miss, "R9 LRU page evicted", {31'd0, s_miss}, 32'h1);
        look(32'h0010_0000, 0, 0);
        chk(s_hit, "R9 touched page kept", {31'd0, s_hit}, 32'h1);
        look(32'h0020_0000, 0, 0);
        chk(s_hit && s_pa == 32'h0060_0000, "R9 new page present", s_pa, 32'h0060_0000);
        refill(20'h00201, 20'h00601, 0);
        look(32'h0010_2000, 0, 0);
        chk(s_miss, "R9 next oldest evicted", {31'd0, s_miss}, 32'h1);
        look(32'h0010_3000, 0, 0);
        chk(s_hit, "R9 younger kept", {31'd0, s_hit}, 32'h1);
    endtask

    task automatic t_resident();
        logic [19:0] pages [16];
        pages[0] = 20'h00100; pages[1] = 20'h00200; pages[2] = 20'h00201;
        for (int i = 3; i < 16; i++) pages[i] = 20'h00100 + 20'(i);
        refill(20'h00105, 20'h00999, 0);
        look(32'h0010_5ABC, 0, 0);
        chk(s_hit && s_pa == 32'h0099_9ABC, "R10 mapping replaced", s_pa, 32'h0099_9ABC);
        for (int i = 0; i < 16; i++) begin
            look({pages[i], 12'h0}, 0, 0);
            chk(s_hit, "R10 no other eviction", {pages[i], 11'd0, s_hit}, {pages[i], 12'h001});
        end
    endtask

    initial begin
        t_reset();
        t_basic();
        t_ref();
        t_dirty();
        t_lru();
        t_resident();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule